// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the word-wide control registers of a host bridge. A processor reaches them over a small register bus that carries only whole 32-bit words. The register index is the word offset. Most registers are plain storage whose contents drive the rest of the bridge through a flat output vector. Writes to unknown offsets are dropped.

The interrupt-enable register is never written directly. Software sets bits in it through a write-one-to-set alias and removes bits through a write-one-to-clear alias. Each alias also keeps the last value written to it. The enable register and the interrupt status register both ignore writes. One bit of the general configuration register acts as a software reset trigger. When a write moves that bit from 0 to 1, the block stores the new value and sends a one-cycle request to the system reset logic.

The reset input is asserted asynchronously and released synchronously through a two-stage synchronizer. Reads return data one cycle after the request.

Top module: `ctrlbank_top`

## Requirements
- R1: The register index is bus_addr[7:2]. Address bits [1:0] are ignored. Indices 0 to 27 (byte offsets 0x00 to 0x6C) form the bank.
- R2: A write to index 12 (offset 0x30) stores the word at index 12 and ORs it into the enable register at index 14 (offset 0x38).
- R3: A write to index 13 (offset 0x34) stores the word at index 13 and clears, in index 14, every bit that is 1 in the word.
- R4: Writes to index 14 (0x38) and index 15 (0x3C) leave them unchanged. Index 15 reads as zero.
- R5: A write to index 1 (0x04) that changes bit 2 from 0 to 1 stores the word and sets sys_rst_req high for exactly the one cycle after the write. A write that leaves bit 2 at 1, or writes it as 0, produces no pulse.
- R6: After reset the registers hold these values: 0x00000C40 at 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and at 0x20, 0x00000008 at 0x68, and 0x10000000 at 0x6C. Every other register holds zero.
- R7: Writes to indices 28 to 63 change no register. Reads of those indices return zero.
- R8: A read request (bus_sel=1, bus_wr=0) places the addressed word on bus_rdata, and sets bus_rvalid high, in the cycle after the request. bus_rvalid is low after a write or an idle cycle.
- R9: Every writable register other than the alias pair stores the full 32-bit word written to it. Register i appears on cfg_regs[32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cfg_regs | output | 896 | All register contents, register i at bits [32*i+31:32*i] |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- the set and clear aliases act on the enable register;
- writes aimed at the enable register or at out-of-range indices leave the register vector unchanged;
- the reset request is a lone pulse that only a 0-to-1 write of the trigger bit can cause;
- read-valid follows read requests by one cycle.

Other behaviour only the bench's scenarios can show. This covers the reset defaults, the contents of the read data, the masking of the low address bits, and that a repeated write of the trigger bit gives no further pulse. The bench shows these by comparing read-backs and the register vector with its own model, under random traffic and directed cases.

// File: rtl/ctrlbank_pkg.sv
package ctrlbank_pkg;

  localparam int WORD_W     = 32;
  localparam int BANK_REGS  = 28;
  localparam int BADDR_W    = 8;

  // register indices whose behaviour is special
  localparam int IDX_GEN    = 1;
  localparam int IDX_ENSET  = 12;
  localparam int IDX_ENCLR  = 13;
  localparam int IDX_EN     = 14;
  localparam int IDX_ISR    = 15;
  localparam int GEN_RST_BIT = 2;

  // reset value of each register index
  function automatic logic [WORD_W-1:0] reset_value(input int idx);
    logic [WORD_W-1:0] v;
    case (idx)
      0:       v = 32'h0000_0C40;
      1:       v = 32'h0000_1384;
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7:       v = 32'h0000_01FF;
      8:       v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ctrlbank_decode.sv
module ctrlbank_decode
  import ctrlbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int ADDR_W   = BADDR_W
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);

  localparam int IDXW = ADDR_W - 2;

  logic [IDXW-1:0] idx;
  logic            wr_req;
  logic            rd_req;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign wr_req = bus_sel & bus_wr;
  assign rd_req = bus_sel & ~bus_wr;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    logic match;
    assign match = (idx == IDXW'(i));
    assign rd_hit[i] = rd_req & match;
    if (i == IDX_EN || i == IDX_ISR) begin : g_ro
      assign wr_hit[i] = 1'b0;
    end else begin : g_rw
      assign wr_hit[i] = wr_req & match;
    end
  end

endmodule

// File: rtl/ctrlbank_regs.sv
module ctrlbank_regs
  import ctrlbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int DATA_W   = WORD_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_hit,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = DATA_W'(reset_value(i));

    if (i == IDX_ISR) begin : g_status
      // read-only status word, no source inside this block
      assign regs_q[i] = RV;
    end else begin : g_store
      logic [DATA_W-1:0] d;
      logic              load;

      if (i == IDX_EN) begin : g_en
        always_comb begin
          d    = regs_q[i];
          load = 1'b0;
          if (wr_hit[IDX_ENSET]) begin
            d    = regs_q[i] | wdata;
            load = 1'b1;
          end else if (wr_hit[IDX_ENCLR]) begin
            d    = regs_q[i] & ~wdata;
            load = 1'b1;
          end
        end
      end else begin : g_plain
        always_comb begin
          d    = wdata;
          load = wr_hit[i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[i] <= RV;
        end else if (load) begin
          regs_q[i] <= d;
        end
      end
    end
  end

endmodule

// File: rtl/ctrlbank_rstreq.sv
module ctrlbank_rstreq (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);

  logic req_d;

  always_comb begin
    req_d = gen_wr & ~old_bit & new_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= req_d;
    end
  end

endmodule

// File: rtl/ctrlbank_rdport.sv
module ctrlbank_rdport #(
  parameter int NUM_REGS = 28,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_req,
  input  logic [NUM_REGS-1:0]              rd_hit,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
  output logic [DATA_W-1:0]                rdata,
  output logic                             rvalid
);

  logic [DATA_W-1:0] rdata_d;

  // one-hot AND-OR selection, zero when no index matches
  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rdata_d = rdata_d | (regs_q[i] & {DATA_W{rd_hit[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_req) begin
      rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
    end
  end

endmodule

// File: rtl/ctrlbank_top.sv
module ctrlbank_top
  import ctrlbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = BADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  output logic                       sys_rst_req
);

  logic [1:0]                       rst_sync;
  logic                             rst_n_sync;
  logic [NUM_REGS-1:0]              wr_hit;
  logic [NUM_REGS-1:0]              rd_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync[1];

  ctrlbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit)
  );

  ctrlbank_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .regs_q (regs_q)
  );

  ctrlbank_rstreq u_rstreq (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .gen_wr  (wr_hit[IDX_GEN]),
    .old_bit (regs_q[IDX_GEN][GEN_RST_BIT]),
    .new_bit (bus_wdata[GEN_RST_BIT]),
    .req     (sys_rst_req)
  );

  ctrlbank_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rdport (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .rd_req (bus_sel & ~bus_wr),
    .rd_hit (rd_hit),
    .regs_q (regs_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  assign cfg_regs = regs_q;

endmodule

// File: rtl/ctrlbank_chk.sv
module ctrlbank_chk
  import ctrlbank_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS,
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = BADDR_W
) (
  input logic                       clk,
  input logic                       rst_n_sync,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       bus_rvalid,
  input logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  input logic                       sys_rst_req
);

  localparam int IDXW = ADDR_W - 2;

  logic [IDXW-1:0]   idx;
  logic              wr_req;
  logic              rd_req;
  logic [DATA_W-1:0] en_w;
  logic [DATA_W-1:0] set_w;
  logic [DATA_W-1:0] clr_w;
  logic              gen_bit;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_req  = bus_sel & bus_wr;
  assign rd_req  = bus_sel & ~bus_wr;
  assign en_w    = cfg_regs[IDX_EN*DATA_W +: DATA_W];
  assign set_w   = cfg_regs[IDX_ENSET*DATA_W +: DATA_W];
  assign clr_w   = cfg_regs[IDX_ENCLR*DATA_W +: DATA_W];
  assign gen_bit = cfg_regs[IDX_GEN*DATA_W + GEN_RST_BIT];

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_req && idx == IDXW'(IDX_ENSET)) |=>
      (((en_w & $past(bus_wdata)) == $past(bus_wdata)) && (set_w == $past(bus_wdata))));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_req && idx == IDXW'(IDX_ENCLR)) |=>
      (((en_w & $past(bus_wdata)) == '0) && (clr_w == $past(bus_wdata))));

  p_ro_write_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_req && (idx == IDXW'(IDX_EN) || idx == IDXW'(IDX_ISR))) |=> $stable(cfg_regs));

  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    sys_rst_req |=> !sys_rst_req);

  p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    sys_rst_req |-> $past(wr_req && idx == IDXW'(IDX_GEN) &&
                          bus_wdata[GEN_RST_BIT] && !gen_bit));

  p_unknown_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_req && int'(idx) >= NUM_REGS) |=> $stable(cfg_regs));

  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rd_req |=> bus_rvalid);

  p_no_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rd_req |=> !bus_rvalid);

endmodule

bind ctrlbank_top ctrlbank_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) i_ctrlbank_chk (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rvalid  (bus_rvalid),
  .cfg_regs    (cfg_regs),
  .sys_rst_req (sys_rst_req)
);

// File: tb/test_ctrlbank_top.sv
`timescale 1ns/1ps
module test_ctrlbank_top;

  localparam int NR = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NR*32-1:0] cfg_regs;
  logic          sys_rst_req;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  logic [31:0] m [NR];

  always #2.5 clk = ~clk;

  ctrlbank_top i_ctrlbank_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_regs(cfg_regs), .sys_rst_req(sys_rst_req)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0000_0C40;
      1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;
      3: return 32'h255E_0091;
      4: return 32'h0000_6140;
      7, 8: return 32'h0000_01FF;
      26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  // model of one write, returns the expected reset pulse
  function automatic bit model_write(input int idx, input logic [31:0] d);
    bit p = 0;
    if (idx >= NR) return 0;
    case (idx)
      14, 15: ;
      12: begin m[12] = d; m[14] = m[14] | d; end
      13: begin m[13] = d; m[14] = m[14] & ~d; end
      1: begin p = !m[1][2] && d[2]; m[1] = d; end
      default: m[idx] = d;
    endcase
    return p;
  endfunction

  function automatic logic [31:0] exp_read(input int idx);
    return (idx < NR) ? m[idx] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req);
    int bad = -1;
    for (int i = 0; i < NR; i++)
      if (bad < 0 && cfg_regs[i*32 +: 32] !== m[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s reg%0d act=%h exp=%h", req, bad, cfg_regs[bad*32 +: 32], m[bad]);
    end
  endtask

  // write, then sample the pulse in the next cycle and the one after
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    bit ep;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    ep = model_write(int'(a[7:2]), d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check({req, " R5 pulse"}, {31'd0, sys_rst_req}, {31'd0, ep});
    check({req, " R8 no rvalid"}, {31'd0, bus_rvalid}, 32'd0);
    @(negedge clk);
    check({req, " R5 pulse end"}, {31'd0, sys_rst_req}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    check({req, " R8 rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    check(req, bus_rdata, exp_read(int'(a[7:2])));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R8 act=timeout exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < NR; i++) m[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R6 reset state
    check("R5 idle pulse", {31'd0, sys_rst_req}, 32'd0);
    check("R8 idle rvalid", {31'd0, bus_rvalid}, 32'd0);
    check_cfg("R6 defaults on cfg_regs");
    for (int i = 0; i < NR; i++) rd(8'(i*4), "R6 reset read");

    // R1 low bits ignored, R7 out of range
    wr(8'h4B, 32'hA5A5_0001, "R1 misaligned write");
    rd(8'h49, "R1 misaligned read");
    rd(8'h70, "R7 read beyond bank");
    wr(8'hFC, 32'hFFFF_FFFF, "R7 write beyond bank");
    check_cfg("R7 unknown write ignored");

    // R2 / R3 aliases
    wr(8'h30, 32'h0000_00F0, "R2 set");
    rd(8'h38, "R2 enable after set");
    rd(8'h30, "R2 alias stored");
    wr(8'h30, 32'h8000_0001, "R2 set more");
    rd(8'h38, "R2 enable accumulates");
    wr(8'h34, 32'h0000_0030, "R3 clear");
    rd(8'h38, "R3 enable after clear");
    rd(8'h34, "R3 alias stored");

    // R4 read-only registers
    wr(8'h38, 32'h1234_5678, "R4 enable write");
    rd(8'h38, "R4 enable unchanged");
    wr(8'h3C, 32'hFFFF_FFFF, "R4 status write");
    rd(8'h3C, "R4 status zero");

    // R5 trigger bit: default has bit 2 set, so no pulse; clear; set -> pulse
    wr(8'h04, 32'h0000_1384, "R5 bit already set");
    wr(8'h04, 32'h0000_0000, "R5 clear bit");
    wr(8'h04, 32'h0000_0004, "R5 rising bit");
    rd(8'h04, "R5 stored value");
    wr(8'h04, 32'h0000_0004, "R5 repeat set");

    // R9 plain full-word storage
    wr(8'h6C, 32'hDEAD_BEEF, "R9 last register");
    wr(8'h00, 32'h0123_4567, "R9 first register");
    check_cfg("R9 cfg_regs mapping");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      int idx;
      logic [7:0] a;
      sel = $urandom % 10;
      if (sel < 6)       idx = $urandom % NR;
      else if (sel == 6) idx = NR + ($urandom % (64 - NR));
      else if (sel == 7) idx = ($urandom % 2) ? 1 : 12 + ($urandom % 3);
      else if (sel == 8) idx = 15;
      else               idx = 1;
      a = {idx[5:0], 2'($urandom)};
      if ($urandom % 2) wr(a, $urandom, "R9 random write");
      else              rd(a, "R9 random read");
      if (n % 50 == 0) check_cfg("R9 random cfg_regs");
    end
    check_cfg("R9 final cfg_regs");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule